// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block is a 32-bit event counter for a processor core's performance monitor. A 6-bit selector chooses which core event the counter accumulates on each clock. Most events are single strobes. Some supply a count of up to two per cycle. One watches a chosen bit of the 64-bit time base for rising edges, and one counts every flip of the privilege-state level. Software can load the counter at any time through a write port, and the running value is always visible on a registered output.

Edge and flip detection is done inside the block. Each detector keeps the previous sample of the bit it watches, so a single transition is counted exactly once. A detector does not count on the first clock after reset. It also does not count on the first clock after the time-base tap has been moved to a different bit. The block only selects, detects and accumulates.

Top module: `perf_event_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count_q` becomes 0.
- R2: With select code 0, `count_q` holds its value, whatever the event inputs do.
- R3: With select code 1, `count_q` increases by one at every clock.
- R4: With select code 2, the counter adds the completed-instruction count minus the folded-branch count. Each of these inputs is taken as min(value, 2). When the folded count is greater than or equal to the completed count, the counter adds 0.
- R5: With select code 3, the counter adds one for each 0-to-1 transition of one time-base bit. `tb_tap_sel` picks the bit: 0 selects bit 47, 1 selects bit 51, 2 selects bit 55 and 3 selects bit 63. A level that stays high is not counted again, and the other time-base bits have no effect.
- R6: The edge and flip detectors count nothing at the first clock after reset. The time-base edge detector also counts nothing at the first clock after `tb_tap_sel` changes value.
- R7: With select code 4, the counter adds min(`disp_cnt`, 2). In any cycle without a write, the counter never advances by more than 2.
- R8: With select code 9, the counter adds one for every change of `priv_lvl`, from low to high and from high to low.
- R9: Select codes 5 to 8 count `ev_strobe[0]` to `ev_strobe[3]`. Codes 10 to 16 count `ev_strobe[4]` to `ev_strobe[10]`. Each code adds one per cycle in which its own strobe is high, and the other strobes have no effect.
- R10: Select codes 17 to 63 leave `count_q` unchanged.
- R11: When `wr_en` is high at a clock edge, `count_q` takes `wr_data`, and any increment in that cycle is discarded.
- R12: The counter wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_sel | input | 6 | Event select code |
| tb_tap_sel | input | 2 | Time-base bit choice for code 3 |
| time_base | input | 64 | Time-base value |
| cmpl_cnt | input | 2 | Instructions completed this cycle |
| fold_cnt | input | 2 | Folded branches among the completed instructions |
| disp_cnt | input | 2 | Instructions dispatched this cycle |
| priv_lvl | input | 1 | Privilege-state level |
| ev_strobe | input | 11 | Single-event strobes for codes 5-8 and 10-16 |
| wr_en | input | 1 | Software write enable |
| wr_data | input | 32 | Software write value |
| count_q | output | 32 | Counter value |

## Verification
A software load and an event increment can arrive on the same clock. This is provoked by raising `wr_en` while code 1 is selected, so that an increment of one is certain. The counter must then show exactly the written value, and one cycle later that value plus one. The tap selector and an edge can also coincide: the tap is moved onto a bit that is already high while code 3 is selected, and the count must not move.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int CNT_W  = 32;
  localparam int SEL_W  = 6;
  localparam int INC_W  = 2;
  localparam int STRB_N = 11;

  typedef enum logic [SEL_W-1:0] {
    EV_HOLD       = 6'd0,
    EV_CYCLE      = 6'd1,
    EV_RETIRE     = 6'd2,
    EV_TB_RISE    = 6'd3,
    EV_DISPATCH   = 6'd4,
    EV_IL1_MISS   = 6'd5,
    EV_ITRANS_MIS = 6'd6,
    EV_IL2_MISS   = 6'd7,
    EV_BR_NT      = 6'd8,
    EV_PRIV_FLIP  = 6'd9,
    EV_RSV_LOAD   = 6'd10,
    EV_LDST       = 6'd11,
    EV_SNOOP      = 6'd12,
    EV_CASTOUT    = 6'd13,
    EV_SYS_UNIT   = 6'd14,
    EV_FETCH_MISS = 6'd15,
    EV_SPEC_OK    = 6'd16
  } evt_code_e;

  localparam int STRB_BASE = 5;
  localparam int STRB_SKIP = 9;

  // Select code served by strobe lane g (the flip event sits in the middle).
  function automatic int strobe_code(input int g);
    return (g + STRB_BASE < STRB_SKIP) ? g + STRB_BASE : g + STRB_BASE + 1;
  endfunction

  // Counts per cycle never exceed two.
  function automatic logic [INC_W-1:0] clamp2(input logic [INC_W-1:0] v);
    return (v > 2'd2) ? 2'd2 : v;
  endfunction

endpackage

// File: rtl/pmc_bit_watch.sv
module pmc_bit_watch #(
  parameter bit BOTH_EDGES = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic restart,
  output logic evt
);

  logic prev_lvl;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      armed    <= 1'b0;
    end else begin
      prev_lvl <= lvl;
      armed    <= 1'b1;
    end
  end

  generate
    if (BOTH_EDGES) begin : g_flip
      assign evt = armed && !restart && (lvl ^ prev_lvl);
    end else begin : g_rise
      assign evt = armed && !restart && lvl && !prev_lvl;
    end
  endgenerate

endmodule

// File: rtl/pmc_tb_tap.sv
module pmc_tb_tap #(
  parameter int TB_W = 64,
  parameter int TAP0 = 47,
  parameter int TAP1 = 51,
  parameter int TAP2 = 55,
  parameter int TAP3 = 63
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] time_base,
  input  logic [1:0]      tap_sel,
  output logic            rise
);

  localparam int POS_W = $clog2(TB_W);

  logic [POS_W-1:0] tap_pos;
  logic             tap_bit;
  logic [1:0]       last_sel;
  logic             moved;

  always_comb begin
    case (tap_sel)
      2'd0:    tap_pos = POS_W'(TAP0);
      2'd1:    tap_pos = POS_W'(TAP1);
      2'd2:    tap_pos = POS_W'(TAP2);
      default: tap_pos = POS_W'(TAP3);
    endcase
  end

  assign tap_bit = time_base[tap_pos];

  always_ff @(posedge clk) begin
    if (rst) last_sel <= '0;
    else     last_sel <= tap_sel;
  end

  // A new tap only captures its level on the first clock.
  assign moved = (last_sel != tap_sel);

  pmc_bit_watch #(.BOTH_EDGES(1'b0)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .lvl     (tap_bit),
    .restart (moved),
    .evt     (rise)
  );

endmodule

// File: rtl/pmc_inc_sel.sv
module pmc_inc_sel
  import pmc_pkg::*;
(
  input  logic [SEL_W-1:0]  evt_sel,
  input  logic [INC_W-1:0]  cmpl_cnt,
  input  logic [INC_W-1:0]  fold_cnt,
  input  logic [INC_W-1:0]  disp_cnt,
  input  logic              tb_rise,
  input  logic              priv_flip,
  input  logic [STRB_N-1:0] ev_strobe,
  output logic [INC_W-1:0]  inc
);

  logic [STRB_N-1:0] lane_hit;
  logic              strobe_inc;
  logic [INC_W-1:0]  cmpl_c;
  logic [INC_W-1:0]  fold_c;
  logic [INC_W-1:0]  retire_inc;

  genvar g;
  generate
    for (g = 0; g < STRB_N; g++) begin : g_lane
      localparam logic [SEL_W-1:0] LANE_CODE = SEL_W'(strobe_code(g));
      assign lane_hit[g] = (evt_sel == LANE_CODE) && ev_strobe[g];
    end
  endgenerate

  assign strobe_inc = |lane_hit;

  assign cmpl_c     = clamp2(cmpl_cnt);
  assign fold_c     = clamp2(fold_cnt);
  assign retire_inc = (cmpl_c > fold_c) ? (cmpl_c - fold_c) : '0;

  always_comb begin
    case (evt_sel)
      EV_HOLD:      inc = '0;
      EV_CYCLE:     inc = INC_W'(1);
      EV_RETIRE:    inc = retire_inc;
      EV_TB_RISE:   inc = INC_W'(tb_rise);
      EV_DISPATCH:  inc = clamp2(disp_cnt);
      EV_PRIV_FLIP: inc = INC_W'(priv_flip);
      default:      inc = INC_W'(strobe_inc);
    endcase
  end

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
  parameter int CW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic [IW-1:0] inc,
  output logic [CW-1:0] count_q
);

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (wr_en) count_q <= wr_data;
    else            count_q <= count_q + CW'(inc);
  end

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pmc_pkg::*;
#(
  parameter int TB_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  evt_sel,
  input  logic [1:0]        tb_tap_sel,
  input  logic [TB_W-1:0]   time_base,
  input  logic [INC_W-1:0]  cmpl_cnt,
  input  logic [INC_W-1:0]  fold_cnt,
  input  logic [INC_W-1:0]  disp_cnt,
  input  logic              priv_lvl,
  input  logic [STRB_N-1:0] ev_strobe,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_q
);

  logic             tb_rise;
  logic             priv_flip;
  logic [INC_W-1:0] inc;

  pmc_tb_tap #(.TB_W(TB_W)) u_tap (
    .clk       (clk),
    .rst       (rst),
    .time_base (time_base),
    .tap_sel   (tb_tap_sel),
    .rise      (tb_rise)
  );

  pmc_bit_watch #(.BOTH_EDGES(1'b1)) u_priv (
    .clk     (clk),
    .rst     (rst),
    .lvl     (priv_lvl),
    .restart (1'b0),
    .evt     (priv_flip)
  );

  pmc_inc_sel u_sel (
    .evt_sel   (evt_sel),
    .cmpl_cnt  (cmpl_cnt),
    .fold_cnt  (fold_cnt),
    .disp_cnt  (disp_cnt),
    .tb_rise   (tb_rise),
    .priv_flip (priv_flip),
    .ev_strobe (ev_strobe),
    .inc       (inc)
  );

  pmc_accum #(.CW(CNT_W), .IW(INC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .inc     (inc),
    .count_q (count_q)
  );

endmodule

// File: rtl/perf_event_counter_chk.sv
module perf_event_counter_chk
  import pmc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] evt_sel,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_q
);

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (count_q == '0)); // R1

  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && evt_sel == 6'd0) |=> $stable(count_q)); // R2

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && evt_sel == 6'd1) |=> (count_q == $past(count_q) + 32'd1)); // R3

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((count_q - $past(count_q)) <= 32'd2)); // R7

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && evt_sel > 6'd16) |=> $stable(count_q)); // R10

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (count_q == $past(wr_data))); // R11

endmodule

bind perf_event_counter perf_event_counter_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .evt_sel (evt_sel),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .count_q (count_q)
);

// File: tb/perf_event_counter_tb.sv
`timescale 1ns/1ps
module perf_event_counter_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  evt_sel;
  logic [1:0]  tb_tap_sel;
  logic [63:0] time_base;
  logic [1:0]  cmpl_cnt, fold_cnt, disp_cnt;
  logic        priv_lvl;
  logic [10:0] ev_strobe;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] count_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  perf_event_counter u_dut (
    .clk(clk), .rst(rst), .evt_sel(evt_sel), .tb_tap_sel(tb_tap_sel),
    .time_base(time_base), .cmpl_cnt(cmpl_cnt), .fold_cnt(fold_cnt),
    .disp_cnt(disp_cnt), .priv_lvl(priv_lvl), .ev_strobe(ev_strobe),
    .wr_en(wr_en), .wr_data(wr_data), .count_q(count_q)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] exp);
    checks++;
    if (count_q !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, count_q, exp);
    end
  endtask

  task automatic load(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; evt_sel = 6'd3; tb_tap_sel = 2'd0; time_base = 64'd1 << 47;
    cmpl_cnt = 0; fold_cnt = 0; disp_cnt = 0; priv_lvl = 0; ev_strobe = 0;
    wr_en = 0; wr_data = 0;
    repeat (3) step();
    chk("R1 reset value", 32'd0);
    rst = 1'b0;
    step();
    chk("R6 no edge on first clock after reset", 32'd0);
    step();
    chk("R5 steady high level not counted", 32'd0);
  endtask

  task automatic t_hold();
    evt_sel = 6'd0;
    load(32'h0000_00A5);
    for (int i = 0; i < 5; i++) begin
      ev_strobe = '1; disp_cnt = 2; cmpl_cnt = 2; priv_lvl = ~priv_lvl;
      time_base = ~time_base;
      step();
    end
    ev_strobe = 0; disp_cnt = 0; cmpl_cnt = 0;
    chk("R2 code 0 holds", 32'h0000_00A5);
  endtask

  task automatic t_cycle();
    evt_sel = 6'd1;
    load(32'd10);
    repeat (7) step();
    chk("R3 cycle count", 32'd17);
  endtask

  task automatic t_retire();
    evt_sel = 6'd2;
    load(32'd0);
    cmpl_cnt = 2; fold_cnt = 1; step();
    chk("R4 two completed one folded", 32'd1);
    cmpl_cnt = 2; fold_cnt = 0; step();
    cmpl_cnt = 1; fold_cnt = 2; step();
    cmpl_cnt = 2; fold_cnt = 3; step();
    cmpl_cnt = 3; fold_cnt = 0; step();
    cmpl_cnt = 0; fold_cnt = 0;
    chk("R4 completed minus folded with clamps", 32'd5);
  endtask

  task automatic t_dispatch();
    evt_sel = 6'd4;
    load(32'd100);
    for (int d = 0; d < 4; d++) begin
      disp_cnt = 2'(d);
      step();
    end
    disp_cnt = 0;
    chk("R7 dispatch sum with clamp", 32'd105);
  endtask

  task automatic t_tap(input int k);
    int pos;
    pos = (k == 0) ? 47 : (k == 1) ? 51 : (k == 2) ? 55 : 63;
    evt_sel = 6'd0; tb_tap_sel = 2'(k); time_base = 0;
    step();
    load(32'd0);
    evt_sel = 6'd3;
    time_base[pos] = 1'b1; time_base[pos-1] = 1'b1;
    step();
    chk($sformatf("R5 tap %0d first rise", k), 32'd1);
    time_base[pos-1] = 1'b0;
    step();
    chk($sformatf("R5 tap %0d high level held", k), 32'd1);
    time_base[pos] = 1'b0; time_base[pos-1] = 1'b1;
    step();
    time_base[pos] = 1'b1;
    step();
    time_base = 0;
    chk($sformatf("R5 tap %0d second rise", k), 32'd2);
  endtask

  task automatic t_tap_move();
    evt_sel = 6'd3; tb_tap_sel = 2'd0;
    time_base = 64'd1 << 51;
    step();
    load(32'd0);
    tb_tap_sel = 2'd1;
    step();
    chk("R6 tap move onto high bit not counted", 32'd0);
    step();
    chk("R6 moved tap steady high", 32'd0);
    time_base = 0;
    step();
    time_base = 64'd1 << 51;
    step();
    chk("R5 moved tap counts later rise", 32'd1);
    time_base = 0;
  endtask

  task automatic t_priv();
    evt_sel = 6'd0; priv_lvl = 1'b0;
    step();
    load(32'd0);
    evt_sel = 6'd9;
    priv_lvl = 1'b1; step();
    chk("R8 rising flip", 32'd1);
    step();
    chk("R8 steady level", 32'd1);
    priv_lvl = 1'b0; step();
    chk("R8 falling flip", 32'd2);
  endtask

  task automatic t_strobes();
    for (int i = 0; i < 11; i++) begin
      evt_sel = 6'((i < 4) ? i + 5 : i + 6);
      ev_strobe = 0;
      load(32'd0);
      ev_strobe = ~(11'd1 << i);
      step();
      chk($sformatf("R9 lane %0d ignores others", i), 32'd0);
      ev_strobe = 11'd1 << i;
      step();
      chk($sformatf("R9 lane %0d own strobe", i), 32'd1);
    end
    ev_strobe = 0;
  endtask

  task automatic t_reserved();
    evt_sel = 6'd0;
    load(32'h55);
    for (int c = 17; c < 64; c++) begin
      evt_sel = 6'(c); ev_strobe = '1; disp_cnt = 2; cmpl_cnt = 2;
      priv_lvl = ~priv_lvl; time_base = ~time_base;
      step();
    end
    ev_strobe = 0; disp_cnt = 0; cmpl_cnt = 0; time_base = 0;
    chk("R10 reserved codes idle", 32'h55);
  endtask

  task automatic t_write();
    evt_sel = 6'd1;
    step();
    load(32'h1234);
    chk("R11 write beats increment", 32'h1234);
    step();
    chk("R11 count resumes after write", 32'h1235);
  endtask

  task automatic t_wrap();
    evt_sel = 6'd4; disp_cnt = 2;
    load(32'hFFFF_FFFE);
    disp_cnt = 2;
    step();
    chk("R12 wrap by two", 32'd0);
    disp_cnt = 0; evt_sel = 6'd1;
    load(32'hFFFF_FFFF);
    step();
    chk("R12 wrap by one", 32'd0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_cycle();
    t_retire();
    t_dispatch();
    for (int k = 0; k < 4; k++) t_tap(k);
    t_tap_move();
    t_priv();
    t_strobes();
    t_reserved();
    t_write();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule